// File: doc/BRIEF.md
# I2C Master Register Front End

This block is the software-facing half of an I2C master controller. A host reaches five byte-wide registers over a simple select/acknowledge register bus: control, status, data, a clock-divider setting and the controller's own slave address. Each access to the data register, and some control writes, becomes a byte-level request to a separate bus engine that does the SCL/SDA signalling. The requests are open with target address and direction, send a byte, receive a byte, and close the transfer. The engine answers each request with a completion pulse that carries an acknowledge result, an arbitration-lost indication and, for receives, the byte read.

The front end tracks whether a target address has been accepted, which decides whether a data write is an address phase or a data phase. It keeps the bus-busy, arbitration-lost, received-ACK and interrupt flags, and drives a level interrupt. Reads of the data register are pipelined: a read returns the byte captured by the read before it and starts the next receive. The first read of a message is therefore a dummy read. A register access is acknowledged only after any engine request it started has completed, so the host sees every side effect once `reg_ack` pulses.

Top module: `i2cm_regfront`

## Requirements
- R1: After hardware reset the status register reads 0x81 (bit 7 transfer-complete, bit 0 received-ACK), all other registers read 0x00, `irq` is low and no engine request is pending.
- R2: Byte offsets: own address 0x00, divider 0x04, control 0x08, status 0x0C, data 0x10. Only `reg_wdata[7:0]` is used. The own address keeps bits [7:1] and the divider keeps bits [5:0]. Any other offset reads as zero, and writes to it change nothing.
- R3: The interrupt flag (status bit 1) is set after a successful address phase, data phase or receive, but only when control bit 7 (enable) and bit 6 (interrupt enable) are both 1. `irq` follows the flag.
- R4: A control write with bit 7 clear, while bit 7 is currently set, is a soft reset. If a transfer is open it is first closed with STOP. Every register and all transfer state then return to reset values, except the own address, which is kept.
- R5: Any other control write stores bits [7:2]. If bit 5 (master) is set, bus-busy (status bit 5) is set. If bit 5 is clear, bus-busy is cleared and an open transfer is closed with STOP.
- R6: If that write has bit 2 (repeated start) and bit 5 set and a transfer is open, the transfer is closed with STOP and bit 2 reads back as 0. At most one STOP is issued per control write.
- R7: Writing 0 to status bit 1 clears the interrupt flag and drops `irq`. Writing 0 to bit 4 clears arbitration-lost. Writing 1 to either bit changes nothing.
- R8: Data writes are ignored when enable is clear or master is clear. With no address open, the byte goes out as START: bits [7:1] are the target and bit 0 is the direction. On NACK, received-ACK (status bit 0) is set. On ACK the address is held open, received-ACK is cleared and the interrupt is raised.
- R9: A data write with an address open issues SEND. On NACK, received-ACK is set and the transfer is closed with STOP, so the next data write is an address phase again. On ACK, received-ACK is cleared and the interrupt is raised.
- R10: A data read returns the byte captured by the previous read. In master mode it then replaces that byte. With no address open, or with transmit (control bit 4) set, the new byte is 0xFF and no RECV is issued. Otherwise RECV is issued, the engine's byte is captured and the interrupt is raised.
- R11: Engine opcodes are START=0, SEND=1, RECV=2, STOP=3. `eng_req` and its opcode and byte stay stable until `eng_done`. Only one request is outstanding at a time, and `reg_ack` pulses for one cycle only after the access's last engine completion.
- R12: Any engine completion with `eng_lost` high sets arbitration-lost (status bit 4), unless that completion finishes a soft reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 1 | Access request, held until `reg_ack` |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | DATA_W | Write data (low byte used) |
| reg_rdata | output | DATA_W | Read data, valid with `reg_ack` |
| reg_ack | output | 1 | One-cycle access completion |
| eng_req | output | 1 | Engine request, held until `eng_done` |
| eng_op | output | 2 | Engine opcode |
| eng_byte | output | 8 | Address byte or data byte for the engine |
| eng_done | input | 1 | Engine completion pulse |
| eng_nack | input | 1 | Completion saw NACK |
| eng_lost | input | 1 | Completion lost arbitration |
| eng_rdata | input | 8 | Received byte on RECV completion |
| irq | output | 1 | Level interrupt |

## Verification
Two functions can both fall due on a single control write: the master-bit clear and the repeated-start close both want to end the open transfer. The bench provokes this with a write of 0xC4 while an address is open, and judges it by the STOP count delta (exactly one), cleared bus-busy and a control readback with bit 2 still set. The same pairing arises when a soft reset meets an open transfer, and when a data-phase NACK chains a STOP behind the SEND. In both cases the counted engine operations and the status readback are compared with a bench model. Random accesses with random NACK and arbitration-loss completions then exercise these pairings against that model.

// File: rtl/i2cm_pkg.sv
// Shared types, register offsets, bit positions and masks for the
// I2C master register front end. Assumes byte registers on a byte-offset bus.
package i2cm_pkg;
    localparam int BYTE_W = 8;

    localparam int OFF_OWN = 'h00;
    localparam int OFF_DIV = 'h04;
    localparam int OFF_CTL = 'h08;
    localparam int OFF_STA = 'h0C;
    localparam int OFF_DAT = 'h10;

    // control bits
    localparam int B_EN   = 7;
    localparam int B_IEN  = 6;
    localparam int B_MST  = 5;
    localparam int B_TX   = 4;
    localparam int B_RSTA = 2;
    // status bits
    localparam int S_IAL  = 4;
    localparam int S_IIF  = 1;

    localparam logic [BYTE_W-1:0] OWN_MASK = 8'hFE;
    localparam logic [BYTE_W-1:0] DIV_MASK = 8'h3F;
    localparam logic [BYTE_W-1:0] CTL_MASK = 8'hFC;
    localparam logic [BYTE_W-1:0] IDLE_RD  = 8'hFF;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_SEND  = 2'd1,
        OP_RECV  = 2'd2,
        OP_STOP  = 2'd3
    } eng_op_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_ACK
    } fsm_t;

    typedef enum logic [2:0] {
        PK_NONE,
        PK_ADDR,
        PK_DATA,
        PK_DSTOP,
        PK_RECV,
        PK_CSTOP,
        PK_SRST
    } pend_t;
endpackage

// File: rtl/i2cm_eng_port.sv
// Request side of the bus-engine handshake. Captures an opcode and byte on
// an issue pulse and holds eng_req until the engine pulses eng_done.
// Assumes the caller issues only when idle or in the completion cycle.
module i2cm_eng_port
    import i2cm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  eng_op_t           issue_op,
    input  logic [BYTE_W-1:0] issue_byte,
    output logic              eng_req,
    output logic [1:0]        eng_op,
    output logic [BYTE_W-1:0] eng_byte,
    input  logic              eng_done,
    output logic              fin
);
    // completion is a done pulse while a request is held
    assign fin = eng_req && eng_done;

    // hold the request and its payload until completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_req  <= 1'b0;
            eng_op   <= 2'd0;
            eng_byte <= '0;
        end else if (issue) begin
            eng_req  <= 1'b1;
            eng_op   <= issue_op;
            eng_byte <= issue_byte;
        end else if (fin) begin
            eng_req  <= 1'b0;
        end
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !eng_done) |=> (eng_req && $stable(eng_op) && $stable(eng_byte))); // R11
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> (!eng_req || eng_done)); // R11
endmodule

// File: rtl/i2cm_rdmux.sv
// Register read selection. Pure combinational; unmapped offsets give zero.
// Assumes the data register view is the previously captured receive byte.
module i2cm_rdmux
    import i2cm_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] own,
    input  logic [BYTE_W-1:0] div,
    input  logic [BYTE_W-1:0] ctl,
    input  logic [BYTE_W-1:0] sta,
    input  logic [BYTE_W-1:0] dat,
    output logic [DATA_W-1:0] rdata
);
    // select the addressed byte, zero-extended to the bus width
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(OFF_OWN)) rdata = DATA_W'(own);
        else if (addr == ADDR_W'(OFF_DIV)) rdata = DATA_W'(div);
        else if (addr == ADDR_W'(OFF_CTL)) rdata = DATA_W'(ctl);
        else if (addr == ADDR_W'(OFF_STA)) rdata = DATA_W'(sta);
        else if (addr == ADDR_W'(OFF_DAT)) rdata = DATA_W'(dat);
    end
endmodule

// File: rtl/i2cm_regfront.sv
// I2C master register front end. Decodes register accesses, sequences
// address/data/receive phases as engine requests and keeps the flags.
// Assumes the host holds reg_sel until reg_ack and drops it after.
module i2cm_regfront
    import i2cm_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              reg_ack,
    output logic              eng_req,
    output logic [1:0]        eng_op,
    output logic [BYTE_W-1:0] eng_byte,
    input  logic              eng_done,
    input  logic              eng_nack,
    input  logic              eng_lost,
    input  logic [BYTE_W-1:0] eng_rdata,
    output logic              irq
);
    fsm_t              state_q;
    pend_t             pend_q;
    logic [BYTE_W-1:0] own_q, div_q, ctl_q, rdl_q;
    logic              busy_q, ial_q, iif_q, rxak_q, lat_q, ack_q;
    logic [DATA_W-1:0] rdata_q, mux_out;
    logic [BYTE_W-1:0] sta_byte, wbyte;
    logic              issue, fin, acc;
    eng_op_t           iop;
    pend_t             ipend;
    logic              a_own, a_div, a_ctl, a_sta, a_dat;
    logic              soft_req, ctl_stop, rd_recv, raise_ok;
    logic              unused_hi;

    assign wbyte     = reg_wdata[BYTE_W-1:0];
    assign unused_hi = ^reg_wdata[DATA_W-1:BYTE_W];
    assign sta_byte  = {1'b1, 1'b0, busy_q, ial_q, 2'b00, iif_q, rxak_q};
    assign acc       = (state_q == ST_IDLE) && reg_sel;
    assign a_own     = reg_addr == ADDR_W'(OFF_OWN);
    assign a_div     = reg_addr == ADDR_W'(OFF_DIV);
    assign a_ctl     = reg_addr == ADDR_W'(OFF_CTL);
    assign a_sta     = reg_addr == ADDR_W'(OFF_STA);
    assign a_dat     = reg_addr == ADDR_W'(OFF_DAT);
    assign soft_req  = ctl_q[B_EN] && !wbyte[B_EN];
    assign ctl_stop  = lat_q && (!wbyte[B_MST] || wbyte[B_RSTA]);
    assign rd_recv   = ctl_q[B_MST] && lat_q && !ctl_q[B_TX];
    assign raise_ok  = ctl_q[B_EN] && ctl_q[B_IEN];
    assign irq       = iif_q;
    assign reg_ack   = ack_q;
    assign reg_rdata = rdata_q;

    i2cm_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rdmux (
        .addr(reg_addr), .own(own_q), .div(div_q), .ctl(ctl_q),
        .sta(sta_byte), .dat(rdl_q), .rdata(mux_out)
    );

    i2cm_eng_port u_port (
        .clk(clk), .rst_n(rst_n), .issue(issue), .issue_op(iop),
        .issue_byte(wbyte), .eng_req(eng_req), .eng_op(eng_op),
        .eng_byte(eng_byte), .eng_done(eng_done), .fin(fin)
    );

    // decide whether this cycle starts an engine request and which phase
    always_comb begin
        issue = 1'b0;
        iop   = OP_STOP;
        ipend = PK_NONE;
        if (acc && reg_wr && a_ctl) begin
            if (soft_req ? lat_q : ctl_stop) begin
                issue = 1'b1;
                ipend = soft_req ? PK_SRST : PK_CSTOP;
            end
        end else if (acc && reg_wr && a_dat && ctl_q[B_EN] && ctl_q[B_MST]) begin
            issue = 1'b1;
            iop   = lat_q ? OP_SEND : OP_START;
            ipend = lat_q ? PK_DATA : PK_ADDR;
        end else if (acc && !reg_wr && a_dat && rd_recv) begin
            issue = 1'b1;
            iop   = OP_RECV;
            ipend = PK_RECV;
        end else if ((state_q == ST_WAIT) && fin && (pend_q == PK_DATA) && eng_nack) begin
            issue = 1'b1;
            ipend = PK_DSTOP;
        end
    end

    // register state, phase bookkeeping and access acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= PK_NONE;
            own_q   <= '0;
            div_q   <= '0;
            ctl_q   <= '0;
            rdl_q   <= '0;
            busy_q  <= 1'b0;
            ial_q   <= 1'b0;
            iif_q   <= 1'b0;
            rxak_q  <= 1'b1;
            lat_q   <= 1'b0;
            ack_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            ack_q <= 1'b0;
            if (issue) pend_q <= ipend;
            case (state_q)
                ST_IDLE: if (reg_sel) begin
                    rdata_q <= mux_out;
                    if (reg_wr) begin
                        if (a_own) own_q <= wbyte & OWN_MASK;
                        if (a_div) div_q <= wbyte & DIV_MASK;
                        if (a_ctl && soft_req && !lat_q) begin
                            div_q  <= '0;
                            ctl_q  <= '0;
                            busy_q <= 1'b0;
                            ial_q  <= 1'b0;
                            iif_q  <= 1'b0;
                            rxak_q <= 1'b1;
                            rdl_q  <= '0;
                        end else if (a_ctl && !soft_req) begin
                            ctl_q <= (wbyte & CTL_MASK) &
                                     ~(BYTE_W'(lat_q && wbyte[B_MST] && wbyte[B_RSTA]) << B_RSTA);
                            busy_q <= wbyte[B_MST];
                        end
                        if (a_sta) begin
                            iif_q <= iif_q & wbyte[S_IIF];
                            ial_q <= ial_q & wbyte[S_IAL];
                        end
                    end else if (a_dat && ctl_q[B_MST] && !rd_recv) begin
                        rdl_q <= IDLE_RD;
                    end
                    state_q <= issue ? ST_WAIT : ST_ACK;
                    ack_q   <= !issue;
                end
                ST_WAIT: if (fin) begin
                    if (eng_lost) ial_q <= 1'b1;
                    case (pend_q)
                        PK_ADDR: begin
                            rxak_q <= eng_nack;
                            lat_q  <= !eng_nack;
                            if (!eng_nack && raise_ok) iif_q <= 1'b1;
                        end
                        PK_DATA: begin
                            rxak_q <= eng_nack;
                            if (eng_nack) lat_q <= 1'b0;
                            else if (raise_ok) iif_q <= 1'b1;
                        end
                        PK_RECV: begin
                            rdl_q <= eng_rdata;
                            if (raise_ok) iif_q <= 1'b1;
                        end
                        PK_CSTOP: lat_q <= 1'b0;
                        PK_SRST: begin
                            div_q  <= '0;
                            ctl_q  <= '0;
                            busy_q <= 1'b0;
                            ial_q  <= 1'b0;
                            iif_q  <= 1'b0;
                            rxak_q <= 1'b1;
                            lat_q  <= 1'b0;
                            rdl_q  <= '0;
                        end
                        default: ;
                    endcase
                    if (!issue) begin
                        state_q <= ST_ACK;
                        ack_q   <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (ctl_q[B_EN] && ctl_q[B_IEN])); // R3
    AST_IRQ_FROM_ENGINE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(fin)); // R3
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_ack |=> !reg_ack); // R11
    AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !eng_req); // R11
    AST_OWN_SURVIVES: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_WAIT) && fin && (pend_q == PK_SRST)) |=> $stable(own_q)); // R4
    AST_IIF_WRITE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && reg_wr && a_sta && !wbyte[S_IIF]) |=> !irq); // R7
endmodule

// File: tb/i2cm_regfront_bench.sv
`timescale 1ns/1ps
module i2cm_regfront_bench;
    localparam logic [4:0] A_OWN = 5'h00, A_DIV = 5'h04, A_CTL = 5'h08,
                           A_STA = 5'h0C, A_DAT = 5'h10, A_BAD = 5'h14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        ack, eng_req, irq;
    logic [1:0]  eng_op;
    logic [7:0]  eng_byte;
    logic        eng_done = 1'b0, eng_nack = 1'b0, eng_lost = 1'b0;
    logic [7:0]  eng_rdata = '0;

    int n_tests = 0, n_fail = 0;
    int cnt_op[4] = '{0, 0, 0, 0};
    int wait_cnt = 0;
    bit cfg_nack = 0, cfg_lost = 0;
    logic [7:0] rx_next = 8'h5A, last_byte = '0;

    // bench model of the register state
    bit [7:0] m_own = 0, m_div = 0, m_ctl = 0, m_rdl = 0;
    bit m_busy = 0, m_ial = 0, m_iif = 0, m_rxak = 1, m_lat = 0;

    always #2 clk = ~clk;

    i2cm_regfront u_i2cm_regfront (
        .clk(clk), .rst_n(rst_n), .reg_sel(sel), .reg_wr(wr_en), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata), .reg_ack(ack), .eng_req(eng_req),
        .eng_op(eng_op), .eng_byte(eng_byte), .eng_done(eng_done), .eng_nack(eng_nack),
        .eng_lost(eng_lost), .eng_rdata(eng_rdata), .irq(irq)
    );

    // engine responder: answers each request after a random delay
    always @(negedge clk) begin
        if (eng_done) eng_done = 1'b0;
        else if (eng_req) begin
            if (wait_cnt > 0) wait_cnt--;
            else begin
                eng_done  = 1'b1;
                eng_nack  = cfg_nack;
                eng_lost  = cfg_lost;
                eng_rdata = rx_next;
                cnt_op[int'(eng_op)]++;
                last_byte = eng_byte;
                if (eng_op == 2'd2) rx_next = rx_next + 8'h1D;
                wait_cnt = $urandom_range(0, 3);
            end
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus(input bit w, input logic [4:0] a, input logic [15:0] d,
                       output logic [15:0] q);
        @(negedge clk);
        sel = 1'b1; wr_en = w; addr = a; wdata = d;
        do @(negedge clk); while (!ack);
        q = rdata;
        sel = 1'b0;
    endtask

    function automatic logic [7:0] m_sta();
        return {1'b1, 1'b0, m_busy, m_ial, 2'b00, m_iif, m_rxak};
    endfunction

    task automatic m_raise();
        if (m_ctl[7] && m_ctl[6]) m_iif = 1;
    endtask

    task automatic m_soft();
        m_div = 0; m_ctl = 0; m_busy = 0; m_ial = 0; m_iif = 0;
        m_rxak = 1; m_lat = 0; m_rdl = 0;
    endtask

    function automatic logic [15:0] ops_delta(input int s[4]);
        return {4'(cnt_op[0] - s[0]), 4'(cnt_op[1] - s[1]),
                4'(cnt_op[2] - s[2]), 4'(cnt_op[3] - s[3])};
    endfunction

    task automatic do_wr(input logic [4:0] a, input logic [15:0] d, input string req);
        int s[4];
        int e[4];
        logic [15:0] q;
        logic [7:0] v;
        bit need, clr;
        v = d[7:0];
        s = cnt_op;
        e = '{0, 0, 0, 0};
        case (a)
            A_OWN: m_own = v & 8'hFE;
            A_DIV: m_div = v & 8'h3F;
            A_CTL: if (m_ctl[7] && !v[7]) begin
                if (m_lat) e[3]++;
                m_soft();
            end else begin
                need = m_lat && (!v[5] || v[2]);
                clr = m_lat && v[5] && v[2];
                m_ctl = v & 8'hFC;
                if (clr) m_ctl[2] = 0;
                m_busy = v[5];
                if (need) begin e[3]++; m_lat = 0; if (cfg_lost) m_ial = 1; end
            end
            A_STA: begin m_iif &= v[1]; m_ial &= v[4]; end
            A_DAT: if (m_ctl[7] && m_ctl[5]) begin
                if (cfg_lost) m_ial = 1;
                if (!m_lat) begin
                    e[0]++;
                    if (cfg_nack) m_rxak = 1;
                    else begin m_lat = 1; m_rxak = 0; m_raise(); end
                end else begin
                    e[1]++;
                    if (cfg_nack) begin m_rxak = 1; m_lat = 0; e[3]++; end
                    else begin m_rxak = 0; m_raise(); end
                end
            end
            default: ;
        endcase
        bus(1'b1, a, d, q);
        chk({req, " engine ops"}, ops_delta(s), {4'(e[0]), 4'(e[1]), 4'(e[2]), 4'(e[3])});
        chk({req, " irq"}, 16'(irq), 16'(m_iif));
    endtask

    task automatic do_rd(input logic [4:0] a, input string req, output logic [15:0] q);
        int s[4];
        int e[4];
        logic [7:0] x;
        s = cnt_op;
        e = '{0, 0, 0, 0};
        case (a)
            A_OWN: x = m_own;
            A_DIV: x = m_div;
            A_CTL: x = m_ctl;
            A_STA: x = m_sta();
            A_DAT: x = m_rdl;
            default: x = 0;
        endcase
        if (a == A_DAT && m_ctl[5]) begin
            if (!m_lat || m_ctl[4]) m_rdl = 8'hFF;
            else begin
                e[2]++;
                if (cfg_lost) m_ial = 1;
                m_rdl = rx_next;
                m_raise();
            end
        end
        bus(1'b0, a, 16'h0, q);
        chk({req, " read value"}, q, 16'(x));
        chk({req, " engine ops"}, ops_delta(s), {4'(e[0]), 4'(e[1]), 4'(e[2]), 4'(e[3])});
        chk({req, " irq"}, 16'(irq), 16'(m_iif));
    endtask

    // watchdog: a hung run is one failed check
    initial begin
        #600000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] q;
        int k;
        logic [4:0] ra;
        logic [4:0] radr[6];
        radr = '{A_OWN, A_DIV, A_CTL, A_STA, A_DAT, A_BAD};
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 req idle", 16'(eng_req), 16'h0);
        do_rd(A_STA, "R1 status", q);   chk("R1 status 0x81", q, 16'h0081);
        do_rd(A_CTL, "R1 control", q);  chk("R1 control 0", q, 16'h0000);
        do_rd(A_DAT, "R1 data", q);

        // R2: masks, truncation, unmapped offset
        do_wr(A_OWN, 16'h0013, "R2 own");
        do_rd(A_OWN, "R2 own", q);      chk("R2 own mask", q, 16'h0012);
        do_wr(A_DIV, 16'hAB5A, "R2 div");
        do_rd(A_DIV, "R2 div", q);      chk("R2 div truncate", q, 16'h001A);
        do_wr(A_BAD, 16'h00FF, "R2 bad");
        do_rd(A_BAD, "R2 bad", q);      chk("R2 unmapped zero", q, 16'h0000);
        do_rd(A_OWN, "R2 own kept", q);

        // R8: data write while disabled
        do_wr(A_DAT, 16'h0055, "R8 disabled");

        // R5: master sets busy
        do_wr(A_CTL, 16'h00E0, "R5 master");
        do_rd(A_STA, "R5 busy", q);     chk("R5 status busy", q, 16'h00A1);

        // R8 / R3: address phase ACK
        do_wr(A_DAT, 16'h00A4, "R8 address");
        chk("R8 start byte", 16'(last_byte), 16'h00A4);
        do_rd(A_STA, "R3 flag", q);     chk("R3 status after addr", q, 16'h00A2);

        // R7: write-one no effect, write-zero clears
        do_wr(A_STA, 16'h00FF, "R7 write one");
        do_wr(A_STA, 16'h0000, "R7 write zero");
        chk("R7 irq low", 16'(irq), 16'h0);

        // R9: data phase ACK then NACK
        do_wr(A_DAT, 16'h003C, "R9 data ack");
        do_wr(A_STA, 16'h0000, "R7 clear");
        cfg_nack = 1;
        do_wr(A_DAT, 16'h0077, "R9 data nack");
        cfg_nack = 0;
        do_rd(A_STA, "R9 rxak", q);
        do_wr(A_DAT, 16'h0091, "R9 readdress");

        // R10: dummy read pipeline and transmit-mode reads
        do_rd(A_DAT, "R10 dummy", q);
        do_rd(A_DAT, "R10 second", q);
        do_wr(A_CTL, 16'h00F0, "R10 tx");
        do_rd(A_DAT, "R10 tx read", q);
        do_rd(A_DAT, "R10 tx ff", q);   chk("R10 idle byte", q, 16'h00FF);

        // R6: repeated start with and without an open transfer
        do_wr(A_CTL, 16'h00E4, "R6 rsta open");
        do_rd(A_CTL, "R6 self clear", q); chk("R6 bit2 cleared", q, 16'h00E0);
        do_wr(A_CTL, 16'h00E4, "R6 rsta idle");
        do_rd(A_CTL, "R6 kept", q);     chk("R6 bit2 kept", q, 16'h00E4);
        do_wr(A_CTL, 16'h00E0, "R6 restore");

        // R5 + R6 in one write: single STOP
        do_wr(A_DAT, 16'h0020, "R5 open");
        do_wr(A_CTL, 16'h00C4, "R5 master clear with rsta");
        do_rd(A_CTL, "R5 ctl", q);      chk("R5 ctl readback", q, 16'h00C4);

        // R3: interrupt enable off
        do_wr(A_STA, 16'h0000, "R3 clear");
        do_wr(A_CTL, 16'h00A0, "R3 no ien");
        do_wr(A_DAT, 16'h0020, "R3 addr no ien");
        chk("R3 irq stays low", 16'(irq), 16'h0);

        // R12: arbitration lost then cleared
        cfg_lost = 1;
        do_wr(A_DAT, 16'h0011, "R12 lost");
        cfg_lost = 0;
        do_rd(A_STA, "R12 flag", q);
        do_wr(A_STA, 16'h00EF, "R12 clear");
        do_rd(A_STA, "R12 cleared", q);

        // R4: soft reset with an open transfer keeps own address
        do_wr(A_OWN, 16'h0042, "R4 own");
        do_wr(A_CTL, 16'h00E0, "R4 ien");
        do_wr(A_CTL, 16'h0000, "R4 soft reset");
        do_rd(A_OWN, "R4 own kept", q); chk("R4 own value", q, 16'h0042);
        do_rd(A_STA, "R4 status", q);   chk("R4 status reset", q, 16'h0081);
        do_rd(A_DIV, "R4 div", q);

        // R8: address NACK
        do_wr(A_CTL, 16'h00E0, "R8 enable");
        cfg_nack = 1;
        do_wr(A_DAT, 16'h0050, "R8 addr nack");
        cfg_nack = 0;
        do_rd(A_STA, "R8 nack status", q);

        // random traffic against the model
        for (int i = 0; i < 400; i++) begin
            cfg_nack = ($urandom_range(0, 3) == 0);
            cfg_lost = ($urandom_range(0, 9) == 0);
            k = $urandom_range(0, 9);
            if (k <= 1)
                do_wr(A_CTL, 16'({($urandom_range(0, 15) != 0), 1'($urandom),
                      ($urandom_range(0, 4) != 0), 1'($urandom), 1'($urandom),
                      ($urandom_range(0, 5) == 0), 2'($urandom)}), "R5 rnd ctl");
            else if (k <= 4) do_wr(A_DAT, 16'($urandom), "R9 rnd data");
            else if (k <= 6) do_rd(A_DAT, "R10 rnd read", q);
            else if (k == 7) do_wr(A_STA, 16'($urandom), "R7 rnd status");
            else if (k == 8) begin
                ra = radr[$urandom_range(0, 5)];
                do_rd(ra, "R2 rnd read", q);
            end else do_wr($urandom_range(0, 1) ? A_OWN : A_DIV, 16'($urandom), "R2 rnd cfg");
        end
        cfg_nack = 0; cfg_lost = 0;
        do_rd(A_STA, "R12 final status", q);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule